// File: doc/BRIEF.md
# Refresh Pacer with Bounded Postponement

The block paces REFRESH commands for a synchronous DRAM controller. A free-running interval counter marks one owed refresh every `intervalCycles` clocks. Each owed refresh is added to a backlog count. The block raises a request while that count is nonzero, and the command arbiter answers with a one-cycle grant pulse each time it issues a REFRESH. The arbiter may let up to eight refreshes pile up while it serves other traffic. When the backlog reaches eight, the block flags the request as urgent, and the arbiter must then stop all other commands until the backlog drains.

Two REFRESH commands are never allowed closer together than the refresh recovery time (`recoveryCycles`), and never back to back: at least one idle clock must separate them. The block enforces this by masking its own request after each accepted grant. When the controller runs from a slow clock, slower than 40 ns per period, it raises `slowClock`. Every accepted refresh is then followed by a one-cycle request for a PRECHARGE ALL.

The controller derives both counts from time values by rounding up to whole clocks. For example, a 7.8125 us average interval at 400 MHz gives 3125. A backlog that would exceed eight is not stored. It sets a sticky error flag instead.

Top module: `ref_pacer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `pendingCount`, `refreshReq`, `refreshUrgent`, `prechargeReq` and `overflowErr` are all 0. The interval counter restarts from zero.
- R2: With no grants, `pendingCount` rises by one at the end of every `intervalCycles`-th clock after reset. After k·N clocks with N = `intervalCycles`, it reads k, as long as k ≤ 8. A value of 0 or 1 counts as one clock.
- R3: `refreshReq` is 1 exactly when `pendingCount` is nonzero and no recovery window is running.
- R4: A grant pulse in a cycle where `refreshReq` is 1 is accepted. It lowers `pendingCount` by one at that clock edge. If an interval ends in the same cycle, the count stays unchanged.
- R5: A grant pulse in a cycle where `refreshReq` is 0 is ignored. It leaves `pendingCount` and the recovery window unchanged.
- R6: An accepted grant opens a recovery window. It holds `refreshReq` low for max(`recoveryCycles`, 2) − 1 cycles, so the next accepted grant comes at least max(`recoveryCycles`, 2) clocks later.
- R7: `refreshUrgent` is 1 exactly when `pendingCount` equals 8.
- R8: `pendingCount` never exceeds 8. An interval ending while the count is 8 and no grant is accepted leaves the count at 8 and sets `overflowErr`, which stays set until reset.
- R9: `prechargeReq` is 1 for exactly the one cycle after an accepted grant, and only if `slowClock` was 1 in the grant cycle. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grantPulse | input | 1 | Arbiter issued a REFRESH this cycle |
| intervalCycles | input | 16 | Average refresh interval in clocks |
| recoveryCycles | input | 16 | Minimum clocks between two REFRESH commands |
| slowClock | input | 1 | Clock period above 40 ns; request PRECHARGE ALL after each refresh |
| refreshReq | output | 1 | A refresh is owed and may be issued now |
| refreshUrgent | output | 1 | Backlog is at its limit; other commands must wait |
| pendingCount | output | 4 | Number of owed refreshes (0 to 8) |
| prechargeReq | output | 1 | One-cycle PRECHARGE ALL request after a refresh |
| overflowErr | output | 1 | Sticky: a ninth refresh became owed |

## Verification
Two events can land on the same clock edge: the end of an interval, which adds one to the backlog, and an accepted grant, which removes one. At the limit of eight, the end of an interval can also meet a grant, and that decides whether the error flag is set. Short intervals of two to a few clocks, together with grants issued with random probability, make these collisions frequent. A directed run fills the backlog and holds it at eight. A cycle-by-cycle reference model computed from the requirements then checks that a simultaneous grant keeps the count steady, and that a tick on its own at the limit raises the error flag.

// File: rtl/ref_pacer_pkg.sv
package ref_pacer_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic acceptRef;   // a refresh grant was taken this cycle
  } pacerStrobe_t;

endpackage

// File: rtl/ref_pacer_dp.sv
module ref_pacer_dp
  import ref_pacer_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CntW-1:0] intervalCycles,
  input  logic [CntW-1:0] recoveryCycles,
  input  pacerStrobe_t    strobe,
  output logic            tickDue,
  output logic            gapBusy
);

  localparam int WideW = CntW + 1;

  logic [CntW-1:0] tickCnt;
  logic [CntW-1:0] gapCnt;
  logic [WideW-1:0] tickNext;
  logic [CntW-1:0] gapLoad;

  // interval counter: the tick fires in the cycle that completes the interval
  assign tickNext = {1'b0, tickCnt} + WideW'(1);
  assign tickDue  = (tickNext >= {1'b0, intervalCycles});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickDue) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickNext[CntW-1:0];
    end
  end

  // recovery window: at least one idle cycle, and no less than recoveryCycles
  assign gapLoad = (recoveryCycles < CntW'(2)) ? CntW'(1) : recoveryCycles - CntW'(1);
  assign gapBusy = (gapCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.acceptRef) begin
      gapCnt <= gapLoad;
    end else if (gapBusy) begin
      gapCnt <= gapCnt - CntW'(1);
    end
  end

endmodule

// File: rtl/ref_pacer_ctrl.sv
module ref_pacer_ctrl
  import ref_pacer_pkg::*;
#(
  parameter int MaxPostpone = 8,
  parameter int PendW       = $clog2(MaxPostpone + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             grantPulse,
  input  logic             slowClock,
  input  logic             tickDue,
  input  logic             gapBusy,
  output pacerStrobe_t     strobe,
  output logic             refreshReq,
  output logic             refreshUrgent,
  output logic [PendW-1:0] pendingCount,
  output logic             prechargeReq,
  output logic             overflowErr
);

  localparam logic [PendW-1:0] PendMax = PendW'(MaxPostpone);

  logic accept;

  assign refreshReq       = (pendingCount != '0) && !gapBusy;
  assign accept           = grantPulse && refreshReq;
  assign strobe.acceptRef = accept;
  assign refreshUrgent    = (pendingCount >= PendMax);

  // backlog: tick adds, accepted grant removes, both together cancel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingCount <= '0;
      overflowErr  <= 1'b0;
    end else begin
      if (tickDue && !accept) begin
        if (pendingCount >= PendMax) begin
          overflowErr <= 1'b1;
        end else begin
          pendingCount <= pendingCount + PendW'(1);
        end
      end else if (accept && !tickDue) begin
        pendingCount <= pendingCount - PendW'(1);
      end
    end
  end

  // precharge-all follow-up when the clock is slow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prechargeReq <= 1'b0;
    end else begin
      prechargeReq <= accept && slowClock;
    end
  end

endmodule

// File: rtl/ref_pacer.sv
module ref_pacer
  import ref_pacer_pkg::*;
#(
  parameter int CntW        = 16,
  parameter int MaxPostpone = 8,
  localparam int PendW      = $clog2(MaxPostpone + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             grantPulse,
  input  logic [CntW-1:0]  intervalCycles,
  input  logic [CntW-1:0]  recoveryCycles,
  input  logic             slowClock,
  output logic             refreshReq,
  output logic             refreshUrgent,
  output logic [PendW-1:0] pendingCount,
  output logic             prechargeReq,
  output logic             overflowErr
);

  pacerStrobe_t strobe;
  logic         tickDue;
  logic         gapBusy;

  ref_pacer_dp #(
    .CntW(CntW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .intervalCycles(intervalCycles),
    .recoveryCycles(recoveryCycles),
    .strobe        (strobe),
    .tickDue       (tickDue),
    .gapBusy       (gapBusy)
  );

  ref_pacer_ctrl #(
    .MaxPostpone(MaxPostpone),
    .PendW      (PendW)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .grantPulse   (grantPulse),
    .slowClock    (slowClock),
    .tickDue      (tickDue),
    .gapBusy      (gapBusy),
    .strobe       (strobe),
    .refreshReq   (refreshReq),
    .refreshUrgent(refreshUrgent),
    .pendingCount (pendingCount),
    .prechargeReq (prechargeReq),
    .overflowErr  (overflowErr)
  );

endmodule

// File: rtl/ref_pacer_chk.sv
module ref_pacer_chk #(
  parameter int MaxPostpone = 8,
  parameter int PendW       = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             grantPulse,
  input logic             slowClock,
  input logic             refreshReq,
  input logic             refreshUrgent,
  input logic [PendW-1:0] pendingCount,
  input logic             prechargeReq,
  input logic             overflowErr
);

  // R3: a request always has something owed behind it
  p_req_needs_backlog_r3: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> (pendingCount != '0));

  // R6: an accepted grant is followed by at least one idle cycle
  p_idle_after_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantPulse && refreshReq) |=> !refreshReq);

  // R7: full backlog raises urgency
  p_full_is_urgent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendingCount == PendW'(MaxPostpone)) |-> refreshUrgent);

  // R8: backlog bounded
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendingCount <= PendW'(MaxPostpone));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  // R9: precharge request only follows an accepted grant on a slow clock
  p_pre_follows_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    prechargeReq |-> $past(grantPulse && refreshReq && slowClock));

  // R9: precharge request lasts one cycle unless another grant came
  p_pre_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    prechargeReq |=> !prechargeReq);

endmodule

bind ref_pacer ref_pacer_chk #(
  .MaxPostpone(MaxPostpone),
  .PendW      (PendW)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .grantPulse   (grantPulse),
  .slowClock    (slowClock),
  .refreshReq   (refreshReq),
  .refreshUrgent(refreshUrgent),
  .pendingCount (pendingCount),
  .prechargeReq (prechargeReq),
  .overflowErr  (overflowErr)
);

// File: tb/ref_pacer_tb.sv
`timescale 1ns/1ps
module ref_pacer_tb;

  localparam int CntW  = 16;
  localparam int MaxP  = 8;
  localparam int PendW = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             grantPulse = 1'b0;
  logic [CntW-1:0]  intervalCycles = 16'd5;
  logic [CntW-1:0]  recoveryCycles = 16'd3;
  logic             slowClock = 1'b0;
  logic             refreshReq;
  logic             refreshUrgent;
  logic [PendW-1:0] pendingCount;
  logic             prechargeReq;
  logic             overflowErr;

  int total = 0;
  int bad   = 0;

  // reference model state
  int  mPend = 0;
  int  mTick = 0;
  int  mGap  = 0;
  bit  mErr  = 0;
  bit  mPre  = 0;

  always #5 clk = ~clk;

  ref_pacer #(.CntW(CntW), .MaxPostpone(MaxP)) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .grantPulse    (grantPulse),
    .intervalCycles(intervalCycles),
    .recoveryCycles(recoveryCycles),
    .slowClock     (slowClock),
    .refreshReq    (refreshReq),
    .refreshUrgent (refreshUrgent),
    .pendingCount  (pendingCount),
    .prechargeReq  (prechargeReq),
    .overflowErr   (overflowErr)
  );

  function automatic bit expReq();
    return (mPend != 0) && (mGap == 0);
  endfunction

  function automatic int gapOf(int rec);
    return (rec < 2) ? 1 : rec - 1;
  endfunction

  // model advances on each clock edge from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = 0; mTick = 0; mGap = 0; mErr = 0; mPre = 0;
    end else begin
      bit acc, tk;
      acc = grantPulse && expReq();
      tk  = (mTick + 1 >= int'(intervalCycles));
      mTick = tk ? 0 : mTick + 1;
      mPre  = acc && slowClock;
      if (acc) mGap = gapOf(int'(recoveryCycles));
      else if (mGap > 0) mGap = mGap - 1;
      if (tk && !acc) begin
        if (mPend >= MaxP) mErr = 1;
        else mPend = mPend + 1;
      end else if (acc && !tk) begin
        mPend = mPend - 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    check("R2", "pendingCount", int'(pendingCount), mPend);
    check("R3", "refreshReq", int'(refreshReq), int'(expReq()));
    check("R7", "refreshUrgent", int'(refreshUrgent), int'(mPend == MaxP));
    check("R8", "overflowErr", int'(overflowErr), int'(mErr));
    check("R9", "prechargeReq", int'(prechargeReq), int'(mPre));
  endtask

  task automatic step();
    @(negedge clk);
    checkAll();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

  initial begin
    int prevPend;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "pendingCount in reset", int'(pendingCount), 0);
    check("R1", "refreshReq in reset", int'(refreshReq), 0);
    rstN = 1'b1;
    // first cycle after release
    check("R1", "refreshUrgent", int'(refreshUrgent), 0);
    check("R1", "prechargeReq", int'(prechargeReq), 0);
    check("R1", "overflowErr", int'(overflowErr), 0);

    // R5: grant while nothing owed
    grantPulse = 1'b1;
    step();
    grantPulse = 1'b0;
    check("R5", "pendingCount after ignored grant", int'(pendingCount), 0);

    // R2: 12 idle clocks after release with interval 5 -> 2 owed
    repeat (11) step();
    check("R2", "pendingCount after 12 clocks", int'(pendingCount), 2);

    // R4 / R6: accepted grant, then idle cycle
    grantPulse = 1'b1;
    step();
    grantPulse = 1'b0;
    check("R4", "pendingCount after grant", int'(pendingCount), 1);
    check("R6", "refreshReq during recovery", int'(refreshReq), 0);
    // R5: grant during recovery window is ignored
    grantPulse = 1'b1;
    step();
    grantPulse = 1'b0;
    check("R5", "pendingCount after masked grant", int'(pendingCount), mPend);
    repeat (4) step();

    // overflow region: short interval, no grants
    intervalCycles = 16'd2;
    slowClock = 1'b1;
    repeat (24) step();
    check("R7", "refreshUrgent at limit", int'(refreshUrgent), 1);
    check("R8", "pendingCount saturated", int'(pendingCount), MaxP);
    check("R8", "overflowErr set", int'(overflowErr), 1);

    // grants at the limit with slow clock
    recoveryCycles = 16'd0;
    repeat (12) begin
      grantPulse = refreshReq;
      prevPend = int'(pendingCount);
      step();
      grantPulse = 1'b0;
    end
    check("R9", "prechargeReq pattern", int'(prechargeReq), int'(mPre));
    check("R8", "overflowErr sticky", int'(overflowErr), 1);

    // reset again, then random traffic
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1", "pendingCount after second reset", int'(pendingCount), 0);
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) intervalCycles = 16'($urandom_range(0, 30));
      if ($urandom_range(0, 99) == 0)  recoveryCycles = 16'($urandom_range(0, 12));
      if ($urandom_range(0, 49) == 0)  slowClock = ~slowClock;
      if (refreshReq) grantPulse = ($urandom_range(0, 9) < 3);
      else            grantPulse = ($urandom_range(0, 19) == 0);
      step();
    end
    grantPulse = 1'b0;
    summary();
  end

endmodule